// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steps a 12-bit successive-approximation converter through its fixed conversion cycle. Each cycle is fifteen clock periods long. The first three periods track the analog input and auto-zero the comparator. The remaining twelve periods test one result bit each, from the most significant bit down. The block drives a trial word to an external charge-redistribution DAC and reads back a single comparator bit. At the end of the last period it moves the decided word into a result register and raises a data-ready flag.

An active-low start input controls how the cycles follow each other. If start is held low, conversions run back to back. If start is high at the end of period 1, the sequencer parks in period 2. While parked it keeps tracking and keeps data-ready high. A later low on start resumes the cycle. Two active-low enables drive the result onto a three-state bus: one for the upper byte and one for the lower nibble.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is high, and in the first period after reset, the block is in period 1. `track_o` is 1, `trial_o` is 0, `ready_o` is 0 and the result register holds 0.
- R2: `track_o` and `az_o` are 1 only in periods 1 to 3, including a stall in period 2. `cap_o` is 1 only in periods 4 to 15. `trial_o` is all zeros whenever `track_o` is 1.
- R3: In period 4 `trial_o` equals 12'h800. At the end of period 4, bit 11 keeps the value of `cmp_i`.
- R4: In period p, for p from 5 to 15, `trial_o` holds the bits already decided above bit 15-p, sets bit 15-p to 1, and has every lower bit at 0. At the end of the period, bit 15-p takes the value of `cmp_i`.
- R5: At the end of period 15, the twelve decided bits, with bit 0 taken from `cmp_i` in that period, are loaded into the result register. `cmp_i` is 1 when the input is at or above the trial level. With an ideal comparator this gives straight binary: the result equals the input code, including 0, 4095 and 2048.
- R6: The result register changes only on the load at the end of period 15. It holds its value through the whole next cycle, including any stall.
- R7: `ready_o` becomes 1 at the edge that loads the result, so it is 1 in period 1. It becomes 0 at the edge that ends period 1 when `start_n` is 0.
- R8: When `start_n` stays low, a result is loaded every 15 clock cycles with no idle cycle between conversions.
- R9: If `start_n` is 1 at the end of period 1, the block stays in period 2, with `track_o` 1 and `ready_o` unchanged. The first edge in period 2 that sees `start_n` 0 clears `ready_o` and moves on to period 3.
- R10: `start_n` has no effect at the end of periods 3 to 15, nor at the end of period 2 when the block is not stalled.
- R11: `data_o[11:4]` carries result bits 11 to 4 when `oe_hi_n` is 0 and is high impedance when `oe_hi_n` is 1. `data_o[3:0]` behaves the same way under `oe_lo_n`. The two groups are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Conversion start request, active low |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| track_o | output | 1 | 1 selects track, 0 selects hold |
| az_o | output | 1 | Comparator auto-zero strobe |
| cap_o | output | 1 | Comparator capture strobe; the bit decision is taken at the end of this period |
| trial_o | output | 12 | Trial word sent to the DAC |
| ready_o | output | 1 | Data-ready flag |
| oe_hi_n | input | 1 | Active-low enable for result bits 11 to 4 |
| oe_lo_n | input | 1 | Active-low enable for result bits 3 to 0 |
| data_o | output | 12 | Three-state result bus |

## Verification
Two functions share one clock edge: the edge that ends period 15 loads the result and raises the ready flag, and that same edge restarts tracking with an all-zero trial word. Start requests are sampled at the end of period 1, so a ready fall can never meet a load. The other close call is a stall release: one edge clears ready and also moves the cycle from period 2 to period 3.

The bench provokes both with random stall lengths, including a one-cycle stall. It toggles start randomly in the periods where start must be ignored, and it flips the two output enables randomly every period. In every period it checks the strobes, the trial word, the bus and the flag against a period count of its own. This shows that the new result appears in the same period that tracking restarts, and that a released stall costs exactly the cycles it was held.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Where the sequencer is within a conversion cycle.
  typedef enum logic [1:0] {
    PH_TRACK = 2'd0,
    PH_STALL = 2'd1,
    PH_TEST  = 2'd2
  } phase_e;

  // Number of clock periods in one full conversion cycle.
  function automatic int period_count(input int nbits, input int ntrack);
    return ntrack + nbits;
  endfunction

  // Period (counted from 1) in which result bit bit_idx is decided.
  function automatic int test_period(input int bit_idx, input int nbits, input int ntrack);
    return ntrack + nbits - bit_idx;
  endfunction

endpackage

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
  import sar_seq_pkg::*;
#(
  parameter int NBITS  = 12,
  parameter int NTRACK = 3,
  localparam int NPER  = period_count(NBITS, NTRACK),
  localparam int PW    = $clog2(NPER + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_n,
  output logic [PW-1:0] per_o,
  output phase_e        phase_o,
  output logic          adv_o,
  output logic          last_o,
  output logic          stall_o,
  output logic          clr_rdy_o
);

  localparam logic [PW-1:0] P_FIRST = PW'(1);
  localparam logic [PW-1:0] P_PARK  = PW'(2);
  localparam logic [PW-1:0] P_TRK   = PW'(NTRACK);
  localparam logic [PW-1:0] P_LAST  = PW'(NPER);

  logic [PW-1:0] per_q;
  logic          stall_q;

  logic at_first, at_park, at_last, hold_w;

  assign at_first = (per_q == P_FIRST);
  assign at_park  = (per_q == P_PARK);
  assign at_last  = (per_q == P_LAST);

  // Parked in period 2 until a low start arrives.
  assign hold_w    = at_park && stall_q && start_n;
  assign adv_o     = !hold_w;
  // Ready drops when start is seen in period 1, or when it releases a stall.
  assign clr_rdy_o = !start_n && (at_first || (at_park && stall_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= P_FIRST;
      stall_q <= 1'b0;
    end else begin
      if (adv_o) begin
        per_q <= at_last ? P_FIRST : per_q + PW'(1);
      end
      if (at_first) begin
        stall_q <= start_n;
      end else if (at_park && !start_n) begin
        stall_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (per_q > P_TRK)             phase_o = PH_TEST;
    else if (at_park && stall_q)   phase_o = PH_STALL;
    else                           phase_o = PH_TRACK;
  end

  assign per_o   = per_q;
  assign last_o  = at_last;
  assign stall_o = stall_q;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_seq_pkg::*;
#(
  parameter int NBITS  = 12,
  parameter int NTRACK = 3,
  localparam int NPER  = period_count(NBITS, NTRACK),
  localparam int PW    = $clog2(NPER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [PW-1:0]    per,
  input  logic             cmp,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] fin_o
);

  localparam logic [PW-1:0] P_LAST = PW'(NPER);

  // Each bit is set to 1 one period before its test, decided in its own
  // test period, and cleared when the cycle wraps.
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    localparam logic [PW-1:0] TP     = PW'(test_period(i, NBITS, NTRACK));
    localparam logic [PW-1:0] TP_PRE = PW'(test_period(i, NBITS, NTRACK) - 1);

    logic b_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        b_q <= 1'b0;
      end else if (adv) begin
        if (per == P_LAST)      b_q <= 1'b0;
        else if (per == TP)     b_q <= cmp;
        else if (per == TP_PRE) b_q <= 1'b1;
      end
    end

    assign trial_o[i] = b_q;

    // The LSB is decided by the comparator in the final period itself.
    if (i == 0) begin : g_lsb
      assign fin_o[i] = cmp;
    end else begin : g_upper
      assign fin_o[i] = b_q;
    end
  end

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clr_rdy,
  input  logic [NBITS-1:0] fin,
  output logic [NBITS-1:0] res_o,
  output logic             ready_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      ready_o <= 1'b0;
    end else begin
      if (load) begin
        res_o   <= fin;
        ready_o <= 1'b1;
      end else if (clr_rdy) begin
        ready_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NBITS  = 12,
  parameter int NTRACK = 3,
  parameter int LO_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             cmp_i,
  output logic             track_o,
  output logic             az_o,
  output logic             cap_o,
  output logic [NBITS-1:0] trial_o,
  output logic             ready_o,
  input  logic             oe_hi_n,
  input  logic             oe_lo_n,
  output logic [NBITS-1:0] data_o
);

  localparam int NPER = period_count(NBITS, NTRACK);
  localparam int PW   = $clog2(NPER + 1);
  localparam int HI_W = NBITS - LO_W;

  // Named internal events, also observed by the bound checker.
  logic [PW-1:0]    per_w;
  phase_e           phase_w;
  logic             adv_w;
  logic             load_w;
  logic             stall_w;
  logic             clr_rdy_w;
  logic [NBITS-1:0] fin_w;
  logic [NBITS-1:0] res_w;

  sar_phase_ctl #(.NBITS(NBITS), .NTRACK(NTRACK)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .start_n   (start_n),
    .per_o     (per_w),
    .phase_o   (phase_w),
    .adv_o     (adv_w),
    .last_o    (load_w),
    .stall_o   (stall_w),
    .clr_rdy_o (clr_rdy_w)
  );

  sar_trial_reg #(.NBITS(NBITS), .NTRACK(NTRACK)) u_trial (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv_w),
    .per     (per_w),
    .cmp     (cmp_i),
    .trial_o (trial_o),
    .fin_o   (fin_w)
  );

  sar_result_reg #(.NBITS(NBITS)) u_res (
    .clk     (clk),
    .rst     (rst),
    .load    (load_w),
    .clr_rdy (clr_rdy_w),
    .fin     (fin_w),
    .res_o   (res_w),
    .ready_o (ready_o)
  );

  assign track_o = (phase_w != PH_TEST);
  assign az_o    = (phase_w != PH_TEST);
  assign cap_o   = (phase_w == PH_TEST);

  // Three-state bus, split into an upper and a lower group.
  assign data_o[NBITS-1:LO_W] = oe_hi_n ? {HI_W{1'bz}} : res_w[NBITS-1:LO_W];
  assign data_o[LO_W-1:0]     = oe_lo_n ? {LO_W{1'bz}} : res_w[LO_W-1:0];

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS  = 12,
  parameter int NTRACK = 3,
  parameter int LO_W   = 4,
  localparam int NPER  = NTRACK + NBITS,
  localparam int PW    = $clog2(NPER + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start_n,
  input logic [PW-1:0]    per,
  input logic             stall,
  input logic             load,
  input logic             ready,
  input logic             track,
  input logic             cap,
  input logic [NBITS-1:0] trial,
  input logic [NBITS-1:0] fin,
  input logic [NBITS-1:0] res,
  input logic [NBITS-1:0] data,
  input logic             oe_hi_n,
  input logic             oe_lo_n
);

  localparam logic [PW-1:0] P_FIRST = PW'(1);
  localparam logic [PW-1:0] P_PARK  = PW'(2);
  localparam logic [PW-1:0] P_TRK   = PW'(NTRACK);
  localparam logic [PW-1:0] P_LAST  = PW'(NPER);
  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

  a_r2_trial_zero_tracking: assert property (@(posedge clk) disable iff (rst)
    track |-> (trial == '0 && !cap));

  a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
    (per == P_TRK) |=> (trial == MSB_ONLY && cap));

  a_r5_load_result: assert property (@(posedge clk) disable iff (rst)
    load |=> (ready && track && res == $past(fin)));

  a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(res));

  a_r7_ready_falls: assert property (@(posedge clk) disable iff (rst)
    (per == P_FIRST && !start_n) |=> (!ready && per == P_PARK));

  a_r9_stall_parks: assert property (@(posedge clk) disable iff (rst)
    (per == P_PARK && stall && start_n) |=> (per == P_PARK && track && ready == $past(ready)));

  a_r10_steady_steps: assert property (@(posedge clk) disable iff (rst)
    (per >= P_TRK && per < P_LAST) |=> (per == PW'($past(per) + PW'(1))));

  a_r11_hi_drive: assert property (@(posedge clk) disable iff (rst)
    !oe_hi_n |-> (data[NBITS-1:LO_W] == res[NBITS-1:LO_W]));

  a_r11_lo_drive: assert property (@(posedge clk) disable iff (rst)
    !oe_lo_n |-> (data[LO_W-1:0] == res[LO_W-1:0]));

endmodule

bind sar_seq_ctrl sar_seq_chk #(.NBITS(NBITS), .NTRACK(NTRACK), .LO_W(LO_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_n (start_n),
  .per     (per_w),
  .stall   (stall_w),
  .load    (load_w),
  .ready   (ready_o),
  .track   (track_o),
  .cap     (cap_o),
  .trial   (trial_o),
  .fin     (fin_w),
  .res     (res_w),
  .data    (data_o),
  .oe_hi_n (oe_hi_n),
  .oe_lo_n (oe_lo_n)
);

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_n;
  logic        oe_hi_n;
  logic        oe_lo_n;
  logic        track_o, az_o, cap_o, ready_o;
  logic [11:0] trial_o;
  logic [11:0] data_o;
  logic [11:0] cur_code;
  logic        cmp_i;

  int checks = 0;
  int errors = 0;

  logic [11:0] prev_code;
  logic        have_result;
  logic        exp_rdy;

  always #4 clk = ~clk;

  // Ideal DAC plus comparator: high when the input is at or above the trial level.
  assign cmp_i = (cur_code >= trial_o);

  sar_seq_ctrl u0 (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .cmp_i   (cmp_i),
    .track_o (track_o),
    .az_o    (az_o),
    .cap_o   (cap_o),
    .trial_o (trial_o),
    .ready_o (ready_o),
    .oe_hi_n (oe_hi_n),
    .oe_lo_n (oe_lo_n),
    .data_o  (data_o)
  );

  // Expected trial word in period p for a given input code.
  function automatic logic [11:0] exp_trial(input logic [11:0] code, input int p);
    int k;
    logic [11:0] keep;
    if (p <= 3) return 12'h000;
    k    = 15 - p;
    keep = 12'hFFF << (k + 1);
    return (code & keep) | (12'h001 << k);
  endfunction

  task automatic chk(input logic [11:0] act, input logic [11:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_period(input int p, input string trk_tag, input string rdy_tag);
    logic [11:0] expd;
    logic        trk;
    oe_hi_n = 1'($urandom_range(0, 1));
    oe_lo_n = 1'($urandom_range(0, 1));
    #1;
    trk = (p <= 3);
    expd[11:4] = oe_hi_n ? 8'bzzzzzzzz : prev_code[11:4];
    expd[3:0]  = oe_lo_n ? 4'bzzzz : prev_code[3:0];
    chk({11'd0, track_o}, {11'd0, trk}, trk_tag);
    chk({11'd0, az_o}, {11'd0, trk}, "R2 az strobe");
    chk({11'd0, cap_o}, {11'd0, !trk}, "R2 cap strobe");
    if (p == 4)     chk(trial_o, exp_trial(cur_code, p), "R3 msb trial");
    else if (p > 4) chk(trial_o, exp_trial(cur_code, p), "R4 bit trial");
    else            chk(trial_o, 12'h000, "R2 trial zero");
    if (p == 1 && have_result) chk(data_o, expd, "R5 result R11 enables");
    else                       chk(data_o, expd, "R6 hold R11 enables");
    chk({11'd0, ready_o}, {11'd0, exp_rdy}, rdy_tag);
  endtask

  // One conversion, entered at the negedge inside period 1.
  task automatic conv(input logic [11:0] code, input int stall_len, input bit rnd);
    cur_code = code;
    exp_rdy  = have_result;
    check_period(1, "R2 track p1", have_result ? "R7 R8 ready in period 1" : "R1 ready after reset");
    start_n = (stall_len > 0);
    @(negedge clk);
    if (stall_len == 0) begin
      exp_rdy = 1'b0;
      check_period(2, "R2 track p2", "R7 ready falls");
      start_n = rnd ? 1'($urandom_range(0, 1)) : 1'b0;
      @(negedge clk);
    end else begin
      for (int s = 1; s <= stall_len; s++) begin
        check_period(2, "R9 track in stall", "R9 ready held in stall");
        start_n = (s == stall_len) ? 1'b0 : 1'b1;
        @(negedge clk);
      end
      exp_rdy = 1'b0;
    end
    for (int p = 3; p <= 15; p++) begin
      check_period(p, rnd ? "R10 track steps" : "R2 track", stall_len > 0 ? "R9 ready after release" : "R7 ready low");
      start_n = rnd ? 1'($urandom_range(0, 1)) : 1'b0;
      @(negedge clk);
    end
    prev_code   = code;
    have_result = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed        = int'($urandom(32'd5812));
    rst         = 1'b1;
    start_n     = 1'b0;
    oe_hi_n     = 1'b1;
    oe_lo_n     = 1'b1;
    cur_code    = 12'h000;
    prev_code   = 12'h000;
    have_result = 1'b0;
    exp_rdy     = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state, with both output groups enabled.
    oe_hi_n = 1'b0;
    oe_lo_n = 1'b0;
    #1;
    chk({11'd0, track_o}, 12'd1, "R1 track in reset");
    chk({11'd0, ready_o}, 12'd0, "R1 ready in reset");
    chk(trial_o, 12'h000, "R1 trial in reset");
    chk(data_o, 12'h000, "R1 result in reset");
    @(negedge clk);
    rst = 1'b0;

    // Directed corners: extremes, mid-scale, stalls of several lengths.
    conv(12'h000, 0, 1'b0);
    conv(12'hFFF, 0, 1'b0);
    conv(12'h800, 0, 1'b0);
    conv(12'h001, 3, 1'b0);
    conv(12'hFFE, 1, 1'b0);
    conv(12'hA5A, 0, 1'b1);
    conv(12'h5A5, 2, 1'b1);

    for (int n = 0; n < 40; n++) begin
      logic [11:0] c;
      int          sl;
      c  = 12'($urandom_range(0, 4095));
      sl = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 5)) : 0;
      conv(c, sl, 1'b1);
    end

    // Final period 1: last result visible, ready high.
    exp_rdy = 1'b1;
    check_period(1, "R2 track final", "R7 R8 ready final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule